// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds unsigned binary numbers one bit position per clock. Two right-shifting registers feed a single full-adder cell, least significant bit first. The accumulator register supplies one bit of each pair and receives each new sum bit at its top end. The operand register supplies the other bit. A one-bit carry store, updated with set/clear/hold behaviour, links the bit positions. A built-in step counter ends each addition after exactly `WIDTH` shift steps. It then pulses `done` and stops shifting.

A load command places the two starting values in parallel and clears the carry. While an addition runs, the next operand streams into the top of the operand register, one bit per shift, through a valid/ready bit interface. A bit moves only when `in_valid` and `in_ready` are both high in the same cycle. `in_ready` is high only while an addition is running, `step_en` is high and no command is present. The source may hold `in_valid` low to stall; the block may hold `in_ready` low, and the source must then keep its bit. After an addition ends, a continue command clears the carry and starts another pass with the contents already in place. This adds the streamed operand to the running total, so any number of operands can be summed. A source with no further operand streams zeros.

Top module: `serial_accum_adder`

## Requirements
- R1: A high `load` stores `a_init` in the accumulator and `b_init` in the operand register, clears the carry and the step counter, raises `busy`, and keeps `done` low in the next cycle.
- R2: `in_ready` equals `busy & step_en & ~load & ~cont`. A shift step happens only in a cycle where `in_valid` and `in_ready` are both high. In any other cycle without a command, the accumulator and `carry_out` keep their values.
- R3: On each shift step, both registers move one place toward bit 0. The new accumulator bit `WIDTH-1` equals the XOR of the old accumulator bit 0, the old operand bit 0 and the old carry.
- R4: On a shift step, the carry becomes 1 when both operand bits are 1. It becomes 0 when both are 0. It keeps its value when exactly one is 1.
- R5: The `WIDTH`-th shift step after a command clears `busy` and raises `done` for exactly one cycle. The accumulator then holds the sum modulo 2^WIDTH, and `carry_out` holds bit `WIDTH` of the sum.
- R6: While idle with no command, `acc_q` and `carry_out` stay unchanged until the next `load` or `cont`.
- R7: `in_bit` accepted on each shift step enters operand bit `WIDTH-1`. After `WIDTH` steps, the operand register holds the streamed word, whose first bit is its least significant bit.
- R8: A high `cont` (without `load`) keeps both registers, clears the carry and the step counter, and raises `busy`. An addition after `cont` adds the streamed word to the accumulated total.
- R9: `load` takes priority over `cont` and over shifting. A `load` or `cont` during a running addition restarts the count.
- R10: After reset, `acc_q` is 0, `carry_out` is 0, `busy` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load starting values and begin an addition |
| cont | input | 1 | Begin a further addition on the current contents |
| a_init | input | WIDTH | Starting accumulator value |
| b_init | input | WIDTH | Starting operand value |
| step_en | input | 1 | Shift enable |
| in_valid | input | 1 | Streamed operand bit is valid |
| in_bit | input | 1 | Streamed operand bit, least significant first |
| in_ready | output | 1 | Block accepts the streamed bit this cycle |
| acc_q | output | WIDTH | Accumulator contents |
| carry_out | output | 1 | Stored carry, final carry after completion |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse after the last shift step |

## Verification
The adder is driven with operand pairs that never carry, pairs that carry through every position (all-ones plus one), and mixed patterns where the carry holds across positions with one input bit set. Together these separate the set, clear and hold cases of the carry store. Runs with steady flow are compared against runs where `step_en` and `in_valid` drop in turn, which shows that stalls do not change the result or the step count. A three-operand sum streamed during the first pass checks the serial operand path and the continue command. Commands issued during an addition check the restart and priority rules.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {
    REG_HOLD  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_SHIFT = 2'd2
  } reg_op_e;
endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg
  import sa_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_op_e          op,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  // Each bit either holds, takes its parallel input, or takes its upper neighbour.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_above;
    if (i == WIDTH - 1) begin : g_top
      assign from_above = ser_in;
    end else begin : g_mid
      assign from_above = q[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else begin
        unique case (op)
          REG_LOAD:  q[i] <= par_in[i];
          REG_SHIFT: q[i] <= from_above;
          default:   q[i] <= q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/sa_bit_cell.sv
module sa_bit_cell (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic set_c,
  output logic clr_c
);
  // Sum bit plus the set/clear terms for the carry store.
  always_comb begin
    sum   = x ^ y ^ cin;
    set_c = x & y;
    clr_c = ~(x | y);
  end
endmodule

// File: rtl/sa_carry_store.sv
module sa_carry_store (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic set_c,
  input  logic clr_c,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (clr) begin
      q <= 1'b0;
    end else if (en) begin
      unique case ({set_c, clr_c})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/sa_step_ctrl.sv
module sa_step_ctrl
  import sa_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    cont,
  input  logic    step_req,
  output reg_op_e a_op,
  output reg_op_e b_op,
  output logic    carry_clr,
  output logic    carry_en,
  output logic    fire,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] cnt;
  logic             cmd;

  always_comb begin
    cmd       = load | cont;
    fire      = busy & step_req & ~cmd;
    carry_clr = cmd;
    carry_en  = fire;
    if (load) begin
      a_op = REG_LOAD;
      b_op = REG_LOAD;
    end else if (fire) begin
      a_op = REG_SHIFT;
      b_op = REG_SHIFT;
    end else begin
      a_op = REG_HOLD;
      b_op = REG_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (cmd) begin
      cnt  <= '0;
      busy <= 1'b1;
      done <= 1'b0;
    end else if (fire) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder
  import sa_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cont,
  input  logic [WIDTH-1:0] a_init,
  input  logic [WIDTH-1:0] b_init,
  input  logic             step_en,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic [WIDTH-1:0] acc_q,
  output logic             carry_out,
  output logic             busy,
  output logic             done
);
  reg_op_e          a_op, b_op;
  logic             carry_clr, carry_en, fire;
  logic             sum_bit, set_c, clr_c;
  logic [WIDTH-1:0] b_q;

  assign in_ready = busy & step_en & ~load & ~cont;

  sa_step_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .cont(cont),
    .step_req(step_en & in_valid),
    .a_op(a_op), .b_op(b_op), .carry_clr(carry_clr), .carry_en(carry_en),
    .fire(fire), .busy(busy), .done(done)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_acc (
    .clk(clk), .rst_n(rst_n), .op(a_op), .par_in(a_init),
    .ser_in(sum_bit), .q(acc_q)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_opnd (
    .clk(clk), .rst_n(rst_n), .op(b_op), .par_in(b_init),
    .ser_in(in_bit), .q(b_q)
  );

  sa_bit_cell u_cell (
    .x(acc_q[0]), .y(b_q[0]), .cin(carry_out),
    .sum(sum_bit), .set_c(set_c), .clr_c(clr_c)
  );

  sa_carry_store u_carry (
    .clk(clk), .rst_n(rst_n), .clr(carry_clr), .en(carry_en),
    .set_c(set_c), .clr_c(clr_c), .q(carry_out)
  );
endmodule

// File: rtl/sa_checks.sv
module sa_checks #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             cont,
  input logic [WIDTH-1:0] a_init,
  input logic             step_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] acc_q,
  input logic [WIDTH-1:0] b_q,
  input logic             carry_out,
  input logic             busy,
  input logic             done
);
  logic step;
  assign step = in_valid & in_ready;

  assert_load_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && !carry_out && !done && acc_q == $past(a_init));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !cont && !step) |=> $stable(acc_q) && $stable(carry_out));

  assert_idle_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  assert_sum_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> acc_q[WIDTH-1] == ($past(acc_q[0]) ^ $past(b_q[0]) ^ $past(carry_out)));

  assert_carry_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && acc_q[0] && b_q[0]) |=> carry_out);

  assert_carry_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !acc_q[0] && !b_q[0]) |=> !carry_out);

  assert_carry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (acc_q[0] ^ b_q[0])) |=> $stable(carry_out));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load && !cont) |=> $stable(acc_q) && $stable(carry_out) && !busy);

  assert_cont_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !load) |=> busy && !carry_out && $stable(acc_q) && $stable(b_q));
endmodule

bind serial_accum_adder sa_checks #(.WIDTH(WIDTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .load(load), .cont(cont), .a_init(a_init),
  .step_en(step_en), .in_valid(in_valid), .in_ready(in_ready),
  .acc_q(acc_q), .b_q(b_q), .carry_out(carry_out), .busy(busy), .done(done)
);

// File: tb/sim_serial_accum_adder.sv
`timescale 1ns/1ps
module sim_serial_accum_adder;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, cont = 1'b0, step_en = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic [W-1:0] a_init = '0, b_init = '0;
  logic in_ready, carry_out, busy, done;
  logic [W-1:0] acc_q;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_accum_adder #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .cont(cont), .a_init(a_init),
    .b_init(b_init), .step_en(step_en), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .acc_q(acc_q), .carry_out(carry_out), .busy(busy),
    .done(done)
  );

  // Behavioural reference: integer state, arithmetic updates.
  int m_a = 0, m_b = 0, m_c = 0, m_cnt = 0, m_busy = 0, m_done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_c = 0; m_cnt = 0; m_busy = 0; m_done = 0;
    end else if (load) begin
      m_a = int'(a_init); m_b = int'(b_init); m_c = 0; m_cnt = 0; m_busy = 1; m_done = 0;
    end else if (cont) begin
      m_c = 0; m_cnt = 0; m_busy = 1; m_done = 0;
    end else if (m_busy == 1 && step_en && in_valid) begin
      int x, y, s;
      x = m_a % 2; y = m_b % 2;
      s = (x + y + m_c) % 2;
      m_c = (x + y + m_c) / 2;
      m_a = m_a / 2 + s * (1 << (W - 1));
      m_b = m_b / 2 + int'(in_bit) * (1 << (W - 1));
      m_cnt = m_cnt + 1;
      if (m_cnt == W) begin m_busy = 0; m_done = 1; end
      else m_done = 0;
    end else begin
      m_done = 0;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model, sampled away from the rising edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R3", "acc_q vs model", int'(acc_q), m_a);
      check("R4", "carry vs model", int'(carry_out), m_c);
      check("R5", "busy vs model", int'(busy), m_busy);
      check("R5", "done vs model", int'(done), m_done);
      check("R2", "in_ready vs model", int'(in_ready),
            int'(m_busy == 1 && step_en && !load && !cont));
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Stream one word into the operand side while the addition runs.
  // pattern 0: steady; pattern 1: step_en and in_valid drop in turn.
  task automatic run_pass(input logic [W-1:0] stream, input int pattern);
    int k = 0;
    int guard = 0;
    while (k < W && guard < 1000) begin
      @(negedge clk);
      #1;
      if (pattern == 1) begin
        step_en  = (guard % 3) != 1;
        in_valid = (guard % 4) != 2;
      end else begin
        step_en  = 1'b1;
        in_valid = 1'b1;
      end
      in_bit = stream[k];
      #1;
      if (in_valid && in_ready) k++;
      guard++;
    end
    @(negedge clk);
    #1;
    step_en = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    if (guard >= 1000) begin
      checks++; fails++;
      $display("FAIL R5 pass did not finish: actual %0d steps expected %0d", k, W);
    end
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); #1;
    a_init = a; b_init = b; load = 1'b1;
    @(negedge clk); #1;
    load = 1'b0;
  endtask

  task automatic do_cont();
    @(negedge clk); #1;
    cont = 1'b1;
    @(negedge clk); #1;
    cont = 1'b0;
  endtask

  task automatic check_result(input string tag, input int sum);
    @(negedge clk); #2;
    check(tag, "sum mod 2^W", int'(acc_q), sum % (1 << W));
    check(tag, "carry out", int'(carry_out), (sum >> W) & 1);
    check(tag, "busy low", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R10", "acc after reset", int'(acc_q), 0);
    check("R10", "carry after reset", int'(carry_out), 0);
    check("R10", "busy after reset", int'(busy), 0);
    check("R10", "done after reset", int'(done), 0);
    rst_n = 1'b1;

    // R1/R5: simple sum, steady flow
    do_load(8'h5A, 8'h33);
    #1; check("R1", "busy after load", int'(busy), 1);
    check("R1", "carry cleared", int'(carry_out), 0);
    run_pass(8'h00, 0);
    check_result("R5", 8'h5A + 8'h33);

    // R4/R5: carry rippling through every position
    do_load(8'hFF, 8'h01);
    run_pass(8'h00, 0);
    check_result("R4", 8'hFF + 8'h01);
    // R6: idle with stray enables changes nothing
    @(negedge clk); #1; step_en = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    repeat (5) @(negedge clk);
    #1; step_en = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    check("R6", "carry held idle", int'(carry_out), 1);
    check("R6", "acc held idle", int'(acc_q), 0);
    check("R2", "ready low when idle", int'(in_ready), 0);

    // R2/R4: stalls, mixed bits with carry holds
    do_load(8'hB6, 8'h6D);
    run_pass(8'h00, 1);
    check_result("R2", 8'hB6 + 8'h6D);

    // R7/R8: three operands, third streamed in during the first pass
    do_load(8'h70, 8'h20);
    run_pass(8'h90, 1);
    check_result("R7", 8'h70 + 8'h20);
    do_cont();
    run_pass(8'h00, 0);
    check_result("R8", 8'h90 + 8'h90);

    // R9: load during a running addition restarts it
    do_load(8'h11, 8'h22);
    @(negedge clk); #1; step_en = 1'b1; in_valid = 1'b1; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    #1; step_en = 1'b0; in_valid = 1'b0;
    check("R9", "still busy mid-pass", int'(busy), 1);
    @(negedge clk); #1;
    a_init = 8'hC3; b_init = 8'h5C; load = 1'b1; cont = 1'b1;
    @(negedge clk); #1; load = 1'b0; cont = 1'b0;
    check("R9", "load wins over cont", int'(acc_q), 8'hC3);
    run_pass(8'h00, 0);
    check_result("R9", 8'hC3 + 8'h5C);

    // R8: cont mid-pass restarts count without reloading
    do_load(8'h01, 8'h01);
    @(negedge clk); #1; step_en = 1'b1; in_valid = 1'b1; in_bit = 1'b0;
    @(negedge clk); #1; step_en = 1'b0; in_valid = 1'b0;
    do_cont();
    run_pass(8'h00, 0);
    check("R8", "done after full restarted pass", int'(busy), 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule